// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block holds the interrupt bookkeeping of a serial port. Single-cycle set pulses from the receive, transmit, timeout, modem-line and error detectors elsewhere in the port are latched into an 11-bit raw status register. Software sees two things: an enable mask that it loads with a write strobe, and a write-one-to-clear strobe that acknowledges raw bits.

The raw status is ANDed with the mask to form the masked status. Six interrupt lines are then derived from fixed groups of masked bits:

- one line for any source at all;
- one line each for receive, transmit and receive timeout;
- one line for the modem-line group;
- one line for the error group.

The block does not detect any event itself. It records, masks, clears and fans out.

All outputs are registered and active high. The raw status shows a change on the clock edge that samples the set or clear. The masked status and the interrupt lines follow one edge after a raw or mask change.

Top module: `uart_irq_aggr`

## Requirements
- R1: A 1 on setPulse bit i sets raw bit i at the next clock edge. The bit positions are: ring indicator 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break error 9, overrun 10.
- R2: When clrWrEn is high, every raw bit whose clrWrData bit is 1 is cleared at the next edge. Raw bits whose clrWrData bit is 0 are unchanged.
- R3: If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: maskedStatus equals the raw status ANDed with the enable mask, one clock edge after either of them changes.
- R5: irqOut[0] is high exactly when any bit of the masked status is set.
- R6: irqOut[1], irqOut[2] and irqOut[3] follow masked bits 4 (receive), 5 (transmit) and 6 (receive timeout) respectively.
- R7: irqOut[4] is the OR of masked bits 3..0 (the modem-line group).
- R8: irqOut[5] is the OR of masked bits 10..7 (the error group).
- R9: When maskWrEn is high, the whole mask is replaced by maskWrData at the next edge. The masked status and the lines then reflect the new mask one edge later.
- R10: While rstN is low, the raw status, mask, masked status and all interrupt lines are zero.
- R11: clrWrData has no effect while clrWrEn is low, and maskWrData has no effect while maskWrEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setPulse | input | 11 | Per-source event pulses |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 11 | New enable mask |
| clrWrEn | input | 1 | Clear register write strobe |
| clrWrData | input | 11 | Bits to clear (1 = clear) |
| rawStatus | output | 11 | Raw interrupt status |
| maskedStatus | output | 11 | Raw status ANDed with mask |
| irqOut | output | 6 | Interrupt lines: 0 any, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error |

## Verification
The vector walk sets sources one by one and several at once under a fully open mask, a closed mask and group-selective masks. This separates a wrong group decode on lines 4 and 5 from a wrong per-bit mask.

Clears are applied partially, together with a set on the same bit, and with data present but no strobe. These cases tell write-one-to-clear apart from overwrite, show which side wins a collision, and expose an ignored strobe.

A mid-run reset after the mask was opened checks that mask and status both return to zero.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_W = 11;
  localparam int IRQ_N = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic             loadMask;
    logic [SRC_W-1:0] maskVal;
    logic [SRC_W-1:0] clearBits;
  } ctrlStrobe_t;

  // Source groups feeding each interrupt line
  localparam logic [SRC_W-1:0] IRQ_GROUP [IRQ_N] = '{
    11'h7FF,  // any
    11'h010,  // receive
    11'h020,  // transmit
    11'h040,  // receive timeout
    11'h00F,  // modem lines
    11'h780   // errors
  };
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             maskWrEn,
  input  logic [SRC_W-1:0] maskWrData,
  input  logic             clrWrEn,
  input  logic [SRC_W-1:0] clrWrData,
  output ctrlStrobe_t      strobe
);
  always_comb begin
    strobe.loadMask  = maskWrEn;
    strobe.maskVal   = maskWrData;
    strobe.clearBits = clrWrEn ? clrWrData : '0;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] setPulse,
  input  ctrlStrobe_t      strobe,
  output logic [SRC_W-1:0] rawQ,
  output logic [SRC_W-1:0] maskedQ,
  output logic [IRQ_N-1:0] irqQ
);
  logic [SRC_W-1:0] maskQ;
  logic [SRC_W-1:0] gated;

  assign gated = rawQ & maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ    <= '0;
      maskQ   <= '0;
      maskedQ <= '0;
    end else begin
      // set wins over clear
      rawQ    <= (rawQ & ~strobe.clearBits) | setPulse;
      maskQ   <= strobe.loadMask ? strobe.maskVal : maskQ;
      maskedQ <= gated;
    end
  end

  for (genvar g = 0; g < IRQ_N; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) irqQ[g] <= 1'b0;
      else       irqQ[g] <= |(gated & IRQ_GROUP[g]);
    end
  end
endmodule

// File: rtl/uart_irq_aggr.sv
module uart_irq_aggr
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [10:0]      setPulse,
  input  logic             maskWrEn,
  input  logic [10:0]      maskWrData,
  input  logic             clrWrEn,
  input  logic [10:0]      clrWrData,
  output logic [10:0]      rawStatus,
  output logic [10:0]      maskedStatus,
  output logic [5:0]       irqOut
);
  ctrlStrobe_t strobe;

  uart_irq_ctrl uCtrl (
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .clrWrEn    (clrWrEn),
    .clrWrData  (clrWrData),
    .strobe     (strobe)
  );

  uart_irq_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .setPulse (setPulse),
    .strobe   (strobe),
    .rawQ     (rawStatus),
    .maskedQ  (maskedStatus),
    .irqQ     (irqOut)
  );
endmodule

// File: rtl/uart_irq_aggr_chk.sv
module uart_irq_aggr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [10:0] setPulse,
  input logic        clrWrEn,
  input logic [10:0] clrWrData,
  input logic [10:0] rawStatus,
  input logic [10:0] maskedStatus,
  input logic [5:0]  irqOut
);
  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setPulse) |=> ((rawStatus & $past(setPulse)) == $past(setPulse)));

  // R2
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWrEn |=> ((rawStatus & $past(clrWrData) & ~$past(setPulse)) == 11'h0));

  // R4
  masked_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |=> ((maskedStatus & ~$past(rawStatus)) == 11'h0));

  // R5
  any_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[0] == (|maskedStatus));

  // R6
  rx_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[1] == maskedStatus[4]);

  // R7
  modem_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[4] == (|maskedStatus[3:0]));

  // R8
  err_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[5] == (|maskedStatus[10:7]));

  // R11
  no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrWrEn && $past(rstN)) |=> ((rawStatus & $past(rawStatus)) == $past(rawStatus)));
endmodule

bind uart_irq_aggr uart_irq_aggr_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .setPulse     (setPulse),
  .clrWrEn      (clrWrEn),
  .clrWrData    (clrWrData),
  .rawStatus    (rawStatus),
  .maskedStatus (maskedStatus),
  .irqOut       (irqOut)
);

// File: tb/tb_uart_irq_aggr.sv
`timescale 1ns/1ps
module tb_uart_irq_aggr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] setPulse = '0;
  logic        maskWrEn = 1'b0;
  logic [10:0] maskWrData = '0;
  logic        clrWrEn = 1'b0;
  logic [10:0] clrWrData = '0;
  logic [10:0] rawStatus, maskedStatus;
  logic [5:0]  irqOut;

  int checks = 0;
  int errors = 0;
  logic [10:0] mRaw = '0;
  logic [10:0] mMask = '0;

  always #2 clk = ~clk;

  uart_irq_aggr dut (.*);

  // {set, maskWr, maskData, clrWr, clrData}
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {11'h010, 1'b1, 11'h7FF, 1'b0, 11'h000},
    {11'h020, 1'b0, 11'h000, 1'b0, 11'h000},
    {11'h040, 1'b1, 11'h000, 1'b0, 11'h000},
    {11'h005, 1'b1, 11'h00F, 1'b0, 11'h000},
    {11'h480, 1'b1, 11'h780, 1'b0, 11'h000},
    {11'h000, 1'b1, 11'h070, 1'b1, 11'h0F0},
    {11'h100, 1'b1, 11'h7FF, 1'b1, 11'h100},
    {11'h000, 1'b0, 11'h000, 1'b0, 11'h7FF},
    {11'h008, 1'b1, 11'h780, 1'b1, 11'h7FF},
    {11'h000, 1'b1, 11'h008, 1'b0, 11'h000},
    {11'h000, 1'b0, 11'h7FF, 1'b0, 11'h000}
  };

  function automatic logic [5:0] irqOf(input logic [10:0] m);
    return {|m[10:7], |m[3:0], m[6], m[5], m[4], |m};
  endfunction

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk({req, " raw"}, rawStatus, mRaw);
    chk({req, " masked R4"}, maskedStatus, mRaw & mMask);
    chk({req, " lines R5 R6 R7 R8"}, {5'b0, irqOut}, {5'b0, irqOf(mRaw & mMask)});
  endtask

  task automatic apply(input logic [34:0] v);
    @(negedge clk);
    setPulse   = v[34:24];
    maskWrEn   = v[23];
    maskWrData = v[22:12];
    clrWrEn    = v[11];
    clrWrData  = v[10:0];
    if (clrWrEn) mRaw = mRaw & ~clrWrData;
    mRaw = mRaw | setPulse;
    if (maskWrEn) mMask = maskWrData;
    @(negedge clk);
    setPulse = '0; maskWrEn = 1'b0; clrWrEn = 1'b0; clrWrData = '0; maskWrData = '0;
    chk("R1 R2 R3 R11 raw", rawStatus, mRaw);
    @(negedge clk);
    chkAll("R9 vector");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chkAll("R10 reset");
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R6 transmit and timeout lines alone
    apply({11'h060, 1'b1, 11'h7FF, 1'b1, 11'h7FF});
    chk("R6 tx/rt lines", {5'b0, irqOut}, 11'h00D);

    // R11 mask data without strobe
    apply({11'h000, 1'b0, 11'h000, 1'b0, 11'h000});
    chk("R11 mask kept", maskedStatus, 11'h060);

    // R10 reset mid-run clears mask and status
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    mRaw = '0; mMask = '0;
    chkAll("R10 midrun");
    rstN = 1'b1;
    apply({11'h200, 1'b0, 11'h000, 1'b0, 11'h000});
    chk("R10 mask zero after reset", maskedStatus, 11'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule